// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Event

This block is a watchdog timer that sits on a simple register bus. Software loads a reload value, then enables the timer by writing a code other than the disable code into the control register. While the timer is enabled, a live counter steps down by one on each clock. When the counter reaches zero, the block latches an expiry flag. If the event-select field names a target, the block raises one of three event lines: system reset request, non-maskable interrupt or general-purpose interrupt.

Software keeps the timer from expiring by writing the status register, which reloads the counter from the reload register. The reload register can only be changed while the timer is disabled. Such a write also preloads the counter. The expiry flag stays set until software clears it by writing a one to it. Each register answers only to its own access width, and any other access has no effect.

Top module: `wdt_top`

## Requirements
- R1: After reset the control register reads 0x0AD0, the reload and status registers read 0, and all three event lines are low.
- R2: The timer is disabled when control bits [11:4] hold 0xAD and enabled for any other value. While it is enabled and the status counter is nonzero, the counter drops by exactly one per clock unless it is reloaded in that cycle.
- R3: In any clock where the timer is enabled and the status counter is zero, control bit 15 (expiry flag) is set. The counter stays at zero until it is reloaded.
- R4: Control bits [2:1] select the event: 00 drives the reset line, 01 the NMI line, 10 the GPI line, and 11 none. The selected line is high exactly while the expiry flag is set, and at most one line is ever high.
- R5: Writing 1 to control bit 15 clears the expiry flag and writing 0 leaves it alone. Bits [11:4] and [2:1] take the written value. Bits 0, 3 and [14:12] read 0. If expiry and a clear fall in the same clock, the flag stays set.
- R6: A word write to the reload register (offset 0x4) while the timer is disabled stores the value and also copies it into the status counter.
- R7: A write to the reload register while the timer is enabled changes neither the reload register nor the counter.
- R8: A word write to the status register (offset 0x8) while the timer is enabled loads the counter from the reload register, whatever the data is. While the timer is disabled, such a write is ignored.
- R9: Access width is selected by the word input (1 = 32-bit word, 0 = 16-bit halfword on data bits [15:0]). The control register (offset 0x0) accepts only halfword accesses. The reload and status registers accept only word accesses. A mismatched or unmapped access reads 0 and changes nothing. Read data is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = 32-bit word access, 0 = 16-bit halfword |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| evtReset | output | 1 | Expiry event: reset request |
| evtNmi | output | 1 | Expiry event: non-maskable interrupt |
| evtGpi | output | 1 | Expiry event: general-purpose interrupt |

## Verification
The bench builds the block with its defaults, a 4-bit offset and a 32-bit counter, so the full word path of the reload and status registers is exercised. Reload values are kept below 24. This lets the counter reach zero within a few dozen cycles, so expiry, the hold at zero, flag clearing against a fresh expiry, and each event-select code all occur many times within the random run. Because the random stimulus toggles the enable code often, reload writes and status writes land in both the enabled and the disabled state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTL_W    = 16;
  localparam int unsigned ROLL_BIT = 15;
  localparam int unsigned EN_LSB   = 4;
  localparam int unsigned EN_W     = 8;
  localparam int unsigned SEL_LSB  = 1;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned NUM_EVT  = 3;
  localparam logic [EN_W-1:0] DIS_CODE = 8'hAD;

  typedef enum logic [1:0] {RD_NONE, RD_CTL, RD_CNT, RD_STAT} rd_sel_e;

  typedef struct packed {
    logic    wrCtl;
    logic    wrCnt;
    logic    wrStat;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTL_OFF  = 0,
  parameter int unsigned CNT_OFF  = 4,
  parameter int unsigned STAT_OFF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic hitCtl, hitCnt, hitStat;

  // Width must match the register: halfword for control, word for the rest.
  always_comb begin
    hitCtl  = (busAddr == ADDR_W'(CTL_OFF))  && !busWord;
    hitCnt  = (busAddr == ADDR_W'(CNT_OFF))  &&  busWord;
    hitStat = (busAddr == ADDR_W'(STAT_OFF)) &&  busWord;
    stb = '{wrCtl: 1'b0, wrCnt: 1'b0, wrStat: 1'b0, rdSel: RD_NONE};
    if (busSel) begin
      if (busWrite) begin
        stb.wrCtl  = hitCtl;
        stb.wrCnt  = hitCnt;
        stb.wrStat = hitStat;
      end else if (hitCtl) begin
        stb.rdSel = RD_CTL;
      end else if (hitCnt) begin
        stb.rdSel = RD_CNT;
      end else if (hitStat) begin
        stb.rdSel = RD_STAT;
      end
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtl, stb.wrCnt, stb.wrStat}));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |-> !(stb.wrCtl || stb.wrCnt || stb.wrStat));

  a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> stb.rdSel == RD_NONE);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_EVT-1:0] evt
);
  logic             rollFlag;
  logic [EN_W-1:0]  enCode;
  logic [SEL_W-1:0] evtSel;
  logic [CNT_W-1:0] cntReg, statReg;
  logic             enabled, atZero;
  logic [CTL_W-1:0] ctlView;

  assign enabled = (enCode != DIS_CODE);
  assign atZero  = (statReg == '0);

  always_comb begin
    ctlView = '0;
    ctlView[ROLL_BIT] = rollFlag;
    ctlView[EN_LSB +: EN_W] = enCode;
    ctlView[SEL_LSB +: SEL_W] = evtSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rollFlag <= 1'b0;
      enCode   <= DIS_CODE;
      evtSel   <= '0;
      cntReg   <= '0;
      statReg  <= '0;
    end else begin
      if (stb.wrCtl) begin
        enCode <= wdata[EN_LSB +: EN_W];
        evtSel <= wdata[SEL_LSB +: SEL_W];
      end
      // A fresh expiry beats a clear in the same cycle.
      if (enabled && atZero)
        rollFlag <= 1'b1;
      else if (stb.wrCtl && wdata[ROLL_BIT])
        rollFlag <= 1'b0;
      if (stb.wrCnt && !enabled) begin
        cntReg  <= wdata[CNT_W-1:0];
        statReg <= wdata[CNT_W-1:0];
      end else if (stb.wrStat && enabled) begin
        statReg <= cntReg;
      end else if (enabled && !atZero) begin
        statReg <= statReg - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evt[i] = rollFlag && (evtSel == SEL_W'(i));
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_CTL:  rdata = DATA_W'(ctlView);
      RD_CNT:  rdata = DATA_W'(cntReg);
      RD_STAT: rdata = DATA_W'(statReg);
      default: rdata = '0;
    endcase
  end

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rstN)
    enabled && !atZero && !stb.wrStat |=> statReg == CNT_W'($past(statReg) - 1'b1));

  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    enabled && atZero && !stb.wrStat |=> (statReg == '0) && rollFlag);

  a_r4_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evt));

  a_r5_roll_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rollFlag && !stb.wrCtl |=> rollFlag);

  a_r7_cnt_locked: assert property (@(posedge clk) disable iff (!rstN)
    enabled && stb.wrCnt |=> $stable(cntReg));

  a_r8_stat_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !enabled && stb.wrStat |=> $stable(statReg));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              evtReset,
  output logic              evtNmi,
  output logic              evtGpi
);
  strobe_t            stb;
  logic [NUM_EVT-1:0] evtVec;

  wdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWord(busWord), .busAddr(busAddr), .stb(stb)
  );

  wdt_datapath #(.CNT_W(CNT_W), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .rdata(busRdata), .evt(evtVec)
  );

  assign evtReset = evtVec[0];
  assign evtNmi   = evtVec[1];
  assign evtGpi   = evtVec[2];
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busWord = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtReset, evtNmi, evtGpi;

  always #10 clk = ~clk;

  wdt_top #(.ADDR_W(4), .CNT_W(32)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWord(busWord), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .evtReset(evtReset), .evtNmi(evtNmi), .evtGpi(evtGpi)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mCtl = 16'h0AD0;
  logic [31:0] mCnt = '0, mStat = '0;

  function automatic logic [31:0] expRead(logic [3:0] a, bit w);
    if (a == 4'h0 && !w) return {16'h0, mCtl};
    if (a == 4'h4 && w)  return mCnt;
    if (a == 4'h8 && w)  return mStat;
    return 32'h0;
  endfunction

  function automatic logic [31:0] expEvt();
    if (!mCtl[15]) return 32'h0;
    case (mCtl[2:1])
      2'b00: return 32'h1;
      2'b01: return 32'h2;
      2'b10: return 32'h4;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit sel, bit wr, logic [3:0] a, bit w, logic [31:0] d);
    bit en;
    logic [15:0] nCtl;
    logic [31:0] nCnt, nStat;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = a; busWord = w; busWdata = d;
    #1;
    if (sel && !wr) check(tag, busRdata, expRead(a, w));
    else check({tag, " idle read"}, busRdata, 32'h0);
    en = (mCtl[11:4] != 8'hAD);
    nCtl = mCtl; nCnt = mCnt; nStat = mStat;
    if (en && mStat != 0) nStat = mStat - 1;
    if (sel && wr && a == 4'h0 && !w)
      nCtl = {mCtl[15] & ~d[15], 3'b000, d[11:4], 1'b0, d[2:1], 1'b0};
    if (sel && wr && a == 4'h4 && w && !en) begin nCnt = d; nStat = d; end
    if (sel && wr && a == 4'h8 && w && en) nStat = mCnt;
    if (en && mStat == 0) nCtl[15] = 1'b1;
    @(posedge clk);
    #1;
    mCtl = nCtl; mCnt = nCnt; mStat = nStat;
    check("R4 event lines", {29'h0, evtGpi, evtNmi, evtReset}, expEvt());
  endtask

  function automatic string tagFor(logic [3:0] a, bit w);
    if (a == 4'h0 && !w) return "R5 control";
    if (a == 4'h4 && w)  return "R6 reload";
    if (a == 4'h8 && w)  return "R2 status";
    return "R9 mismatch";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state
    #1 check("R1 events after reset", {29'h0, evtGpi, evtNmi, evtReset}, 32'h0);
    cyc("R1 control reset", 1, 0, 4'h0, 0, 0);
    cyc("R1 reload reset", 1, 0, 4'h4, 1, 0);
    cyc("R1 status reset", 1, 0, 4'h8, 1, 0);
    // R6: preload while disabled
    cyc("R6 write", 1, 1, 4'h4, 1, 32'd5);
    cyc("R6 status preload", 1, 0, 4'h8, 1, 0);
    // R8: status write ignored while disabled
    cyc("R8 write", 1, 1, 4'h8, 1, 32'd99);
    cyc("R8 disabled ignore", 1, 0, 4'h8, 1, 0);
    // R9: width mismatches
    cyc("R9 write", 1, 1, 4'h4, 0, 32'd7);
    cyc("R9 halfword reload", 1, 0, 4'h4, 0, 0);
    cyc("R9 reload kept", 1, 0, 4'h4, 1, 0);
    cyc("R9 word control", 1, 0, 4'h0, 1, 0);
    cyc("R9 unmapped", 1, 0, 4'hC, 1, 0);
    // R2/R4: enable with NMI select
    cyc("R2 enable", 1, 1, 4'h0, 0, 32'h0000_0002);
    cyc("R2 count", 1, 0, 4'h8, 1, 0);
    // R7: reload locked
    cyc("R7 write", 1, 1, 4'h4, 1, 32'd50);
    cyc("R7 reload locked", 1, 0, 4'h4, 1, 0);
    repeat (6) cyc("idle", 0, 0, 0, 0, 0);
    // R3: expiry and hold
    cyc("R3 flag set", 1, 0, 4'h0, 0, 0);
    cyc("R3 hold zero", 1, 0, 4'h8, 1, 0);
    // R5: clear while still at zero -> set wins
    cyc("R5 clear", 1, 1, 4'h0, 0, 32'h0000_8002);
    cyc("R5 set wins", 1, 0, 4'h0, 0, 0);
    // R8: reload then clear
    cyc("R8 reload", 1, 1, 4'h8, 1, 32'hDEAD_BEEF);
    cyc("R8 reloaded", 1, 0, 4'h8, 1, 0);
    cyc("R5 clear", 1, 1, 4'h0, 0, 32'h0000_8004);
    cyc("R5 cleared", 1, 0, 4'h0, 0, 0);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      bit w, wr, sel;
      logic [31:0] d;
      a = 4'(($urandom % 4) * 4);
      w = (a == 4'h0) ? ($urandom % 5 == 0) : ($urandom % 5 != 0);
      sel = ($urandom % 4 != 0);
      wr = ($urandom % 2 == 0);
      if (a == 4'h0)
        d = {16'h0, 1'($urandom), 3'($urandom),
             (($urandom % 3 == 0) ? 8'hAD : 8'($urandom)), 4'($urandom)};
      else
        d = $urandom % 24;
      cyc(tagFor(a, w), sel, wr, a, w, d);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule